// File: doc/BRIEF.md
# Byte-Command Bridge Dispatcher

This block sits behind the byte layer of a two-wire serial slave and turns its write traffic into actions. The slave hands over bus events (start, stop) and a stream of received bytes. The first byte after a start is the address byte. The first byte after a matching write address is a function code, and the bytes after it are routed according to that code.

Codes whose upper nibble is zero and whose lower nibble is non-zero carry a serial-peripheral transfer. The lower nibble becomes the chip-select bitmap, and the data bytes are collected into a transfer buffer. When the stop condition arrives, an external shift engine is launched. The engine reads the buffer and writes its received bytes back in place, then signals completion. A later read addressed to the block streams those returned bytes out. A small fixed command set in the 0xF0 range sets the configuration byte, clears the completion interrupt, enters idle mode, or forwards an operation to a GPIO block.

Both byte directions are valid/ready streams. A received byte is taken on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` drops from the launch of a transfer until the engine reports completion, and the slave must hold the byte until it is taken. A read byte is delivered on a cycle where `tx_valid` and `tx_ready` are both high. `tx_valid` is high only inside an addressed read while no transfer is running. Control and status pins are plain levels or one-cycle pulses.

Top module: `byte_cmd_bridge`

## Requirements
- R1: The block answers to the 7-bit address whose upper four bits are 4'b0101 and whose low three bits come from `addr_strap`, compared against bits 7:1 of the address byte; bit 0 set means a read. `addr_hit` is high from the cycle after a matching address byte is taken until the next start or stop. After a non-matching address byte, every further byte up to the next start is taken and has no effect.
- R2: A code from 0x01 to 0x0F opens a transfer. At the following stop, if at least one data byte was taken, `spi_go` pulses for one cycle, in the cycle after the stop strobe. In that cycle `spi_len` equals the data-byte count and `spi_cs` equals bits 3:0 of the code. With no data bytes there is no pulse.
- R3: At most 200 data bytes are stored. Every further data byte is dropped and adds one to `ovf_cnt`, which saturates at 255. `spi_len` is then 200.
- R4: From the `spi_go` pulse until the cycle after `spi_done`, `rx_ready` and `tx_valid` are low.
- R5: `irq` is set in the cycle after `spi_done` and stays set until a 0xF1 code byte is taken, which clears it from the next cycle.
- R6: Code 0xF0 loads the next byte into `cfg_reg`, whose reset value is 0. Later bytes of the same write do not change it.
- R7: Code 0xF2 sets `idle_mode`. The next matching address byte clears it.
- R8: Codes 0xF4 to 0xF7 map to `gpio_op` 0 (write), 1 (read), 2 (enable) and 3 (configure). For 0xF5, `gpio_req` pulses in the cycle after the code byte is taken, with `gpio_data` equal to 0. For the other three codes, it pulses in the cycle after the next byte is taken, with `gpio_data` equal to that byte.
- R9: Codes 0x00, 0xF3 and 0xF8 to 0xFF, and all bytes following them, have no effect: no change to `cfg_reg`, `irq` or `idle_mode`, no `gpio_req` and no `spi_go`.
- R10: A read returns the buffer from index 0 upward. While the index is below the length of the last completed transfer, it returns the bytes the engine wrote back. From there on, and before any transfer has completed, it returns 0xFF.
- R11: After reset, `addr_hit`, `spi_go`, `irq`, `idle_mode`, `gpio_req`, `tx_valid` and `ovf_cnt` are 0, `cfg_reg` is 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 3 | Low bits of the slave address |
| bus_start | input | 1 | Start or repeated-start strobe |
| bus_stop | input | 1 | Stop strobe |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Received byte can be taken |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Read byte available |
| tx_ready | input | 1 | Slave takes the read byte |
| tx_data | output | 8 | Read byte |
| addr_hit | output | 1 | Current transaction is addressed to the block |
| spi_go | output | 1 | One-cycle transfer launch |
| spi_len | output | 8 | Number of bytes to shift |
| spi_cs | output | 4 | Chip-select bitmap |
| spi_rd_idx | input | 8 | Engine read index into the buffer |
| spi_rd_data | output | 8 | Buffer byte at the engine read index |
| spi_wr_en | input | 1 | Engine writes a received byte |
| spi_wr_idx | input | 8 | Engine write index |
| spi_wr_data | input | 8 | Engine received byte |
| spi_done | input | 1 | Engine finished the transfer |
| cfg_reg | output | 8 | Shift-engine configuration byte |
| irq | output | 1 | Transfer-complete interrupt |
| idle_mode | output | 1 | Idle mode requested |
| gpio_req | output | 1 | One-cycle GPIO operation request |
| gpio_op | output | 2 | GPIO operation |
| gpio_data | output | 8 | GPIO operation argument |
| ovf_cnt | output | 8 | Dropped data bytes, saturating |

## Verification
The assertions assume an orderly slave and engine. `bus_start`, `bus_stop` and a valid byte never share a cycle. `spi_done` and `spi_wr_en` come only between a launch and its completion, and the engine writes only indexes below `spi_len`. The stimulus keeps to this by driving bus events and bytes in separate cycles from tasks. A model engine in the bench acts only after it has seen the launch pulse, and it raises `spi_done` once, after its last write-back.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CODE, ST_XFER, ST_ARG, ST_DROP, ST_READ
  } bridge_state_e;

  typedef enum logic [2:0] {
    FN_NONE, FN_XFER, FN_CFG, FN_IRQCLR, FN_IDLE, FN_GPIO
  } func_kind_e;

  typedef struct packed {
    func_kind_e kind;
    logic [1:0] gpio_op;
    logic       gpio_has_arg;
  } func_dec_t;

endpackage

// File: rtl/bridge_cmd_decode.sv
module bridge_cmd_decode
  import bridge_pkg::*;
(
  input  logic [7:0] code,
  output func_dec_t  dec
);
  always_comb begin
    dec = '{kind: FN_NONE, gpio_op: code[1:0], gpio_has_arg: 1'b0};
    if (code[7:4] == 4'h0) begin
      if (code[3:0] != 4'h0) dec.kind = FN_XFER;
    end else if (code[7:3] == 5'b11110) begin
      unique case (code[2:0])
        3'd0: dec.kind = FN_CFG;
        3'd1: dec.kind = FN_IRQCLR;
        3'd2: dec.kind = FN_IDLE;
        3'd4, 3'd6, 3'd7: begin
          dec.kind = FN_GPIO;
          dec.gpio_has_arg = 1'b1;
        end
        3'd5: dec.kind = FN_GPIO;
        default: dec.kind = FN_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_xfer_buf.sv
module bridge_xfer_buf #(
  parameter int DEPTH = 200,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [7:0]    host_wdata,
  input  logic          eng_we,
  input  logic [IW-1:0] eng_widx,
  input  logic [7:0]    eng_wdata,
  input  logic [IW-1:0] rd_a_idx,
  output logic [7:0]    rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [7:0]    rd_b_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (eng_we && (int'(eng_widx) < DEPTH))
      mem[eng_widx] <= eng_wdata;
    else if (host_we && (int'(host_idx) < DEPTH))
      mem[host_idx] <= host_wdata;
  end

  assign rd_a_data = (int'(rd_a_idx) < DEPTH) ? mem[rd_a_idx] : 8'h00;
  assign rd_b_data = (int'(rd_b_idx) < DEPTH) ? mem[rd_b_idx] : 8'h00;
endmodule

// File: rtl/byte_cmd_bridge.sv
module byte_cmd_bridge
  import bridge_pkg::*;
#(
  parameter int         DEPTH     = 200,
  parameter int         STRAP_W   = 3,
  parameter int         CS_W      = 4,
  parameter logic [6:0] ADDR_BASE = 7'h28,
  parameter int         IW        = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [7:0]         rx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               addr_hit,
  output logic               spi_go,
  output logic [IW-1:0]      spi_len,
  output logic [CS_W-1:0]    spi_cs,
  input  logic [IW-1:0]      spi_rd_idx,
  output logic [7:0]         spi_rd_data,
  input  logic               spi_wr_en,
  input  logic [IW-1:0]      spi_wr_idx,
  input  logic [7:0]         spi_wr_data,
  input  logic               spi_done,
  output logic [7:0]         cfg_reg,
  output logic               irq,
  output logic               idle_mode,
  output logic               gpio_req,
  output logic [1:0]         gpio_op,
  output logic [7:0]         gpio_data,
  output logic [7:0]         ovf_cnt
);
  localparam logic [6:0] OWN_MASK = 7'((1 << STRAP_W) - 1);

  bridge_state_e   state;
  func_kind_e      cur_kind;
  logic [7:0]      code_q;
  logic [1:0]      op_q;
  logic [IW-1:0]   wr_cnt, rd_idx, last_len;
  logic            busy;
  func_dec_t       dec;
  logic [7:0]      buf_rd_a;
  logic [6:0]      own_addr;
  logic            rx_fire, tx_fire, host_we;

  assign own_addr = (ADDR_BASE & ~OWN_MASK) | 7'(addr_strap);
  assign rx_ready = !busy;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_valid = (state == ST_READ) && !busy;
  assign tx_fire  = tx_valid && tx_ready;
  assign host_we  = rx_fire && (state == ST_XFER) && (int'(wr_cnt) < DEPTH);
  assign tx_data  = (rd_idx < last_len) ? buf_rd_a : 8'hFF;

  bridge_cmd_decode u_dec (.code(rx_data), .dec(dec));

  bridge_xfer_buf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
    .clk        (clk),
    .host_we    (host_we),
    .host_idx   (wr_cnt),
    .host_wdata (rx_data),
    .eng_we     (spi_wr_en),
    .eng_widx   (spi_wr_idx),
    .eng_wdata  (spi_wr_data),
    .rd_a_idx   (rd_idx),
    .rd_a_data  (buf_rd_a),
    .rd_b_idx   (spi_rd_idx),
    .rd_b_data  (spi_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_kind  <= FN_NONE;
      code_q    <= '0;
      op_q      <= '0;
      wr_cnt    <= '0;
      rd_idx    <= '0;
      last_len  <= '0;
      busy      <= 1'b0;
      addr_hit  <= 1'b0;
      spi_go    <= 1'b0;
      spi_len   <= '0;
      spi_cs    <= '0;
      cfg_reg   <= '0;
      irq       <= 1'b0;
      idle_mode <= 1'b0;
      gpio_req  <= 1'b0;
      gpio_op   <= '0;
      gpio_data <= '0;
      ovf_cnt   <= '0;
    end else begin
      spi_go   <= 1'b0;
      gpio_req <= 1'b0;
      if (spi_done && busy) begin
        busy     <= 1'b0;
        last_len <= spi_len;
        irq      <= 1'b1;
      end
      if (bus_start) begin
        state    <= ST_ADDR;
        addr_hit <= 1'b0;
      end else if (bus_stop) begin
        state    <= ST_IDLE;
        addr_hit <= 1'b0;
        if (state == ST_XFER && wr_cnt != '0) begin
          spi_go  <= 1'b1;
          spi_len <= wr_cnt;
          spi_cs  <= code_q[CS_W-1:0];
          busy    <= 1'b1;
        end
      end else if (rx_fire) begin
        unique case (state)
          ST_ADDR: begin
            if (rx_data[7:1] == own_addr) begin
              addr_hit  <= 1'b1;
              idle_mode <= 1'b0;
              rd_idx    <= '0;
              state     <= rx_data[0] ? ST_READ : ST_CODE;
            end else begin
              state <= ST_DROP;
            end
          end
          ST_CODE: begin
            code_q   <= rx_data;
            cur_kind <= dec.kind;
            op_q     <= dec.gpio_op;
            state    <= ST_DROP;
            unique case (dec.kind)
              FN_XFER: begin
                wr_cnt <= '0;
                state  <= ST_XFER;
              end
              FN_CFG:    state <= ST_ARG;
              FN_IRQCLR: irq <= 1'b0;
              FN_IDLE:   idle_mode <= 1'b1;
              FN_GPIO: begin
                if (dec.gpio_has_arg) state <= ST_ARG;
                else begin
                  gpio_req  <= 1'b1;
                  gpio_op   <= dec.gpio_op;
                  gpio_data <= 8'h00;
                end
              end
              default: ;
            endcase
          end
          ST_ARG: begin
            state <= ST_DROP;
            if (cur_kind == FN_CFG) cfg_reg <= rx_data;
            else begin
              gpio_req  <= 1'b1;
              gpio_op   <= op_q;
              gpio_data <= rx_data;
            end
          end
          ST_XFER: begin
            if (int'(wr_cnt) < DEPTH) wr_cnt <= wr_cnt + 1'b1;
            else if (ovf_cnt != 8'hFF) ovf_cnt <= ovf_cnt + 1'b1;
          end
          default: ;
        endcase
      end
      if (tx_fire && !bus_start && !bus_stop && rd_idx != '1)
        rd_idx <= rd_idx + 1'b1;
    end
  end

  // R2: launch is a single-cycle pulse with a legal length
  a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |=> !spi_go);
  a_r2_go_len: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> (spi_len != '0 && int'(spi_len) <= DEPTH));
  // R3: the stored-byte count never passes the buffer depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= DEPTH);
  // R4: no byte traffic in the cycle after a launch
  a_r4_stall_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> (!rx_ready && !tx_valid));
  // R5: the interrupt stays until an explicit clear code is taken
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rx_fire && !bus_start && !bus_stop && state == ST_CODE
              && dec.kind == FN_IRQCLR)) |=> irq);
  // R6: configuration changes only on an argument byte
  a_r6_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_fire && state == ST_ARG) |=> $stable(cfg_reg));
  // R9: an unused code leaves every side output untouched
  a_r9_ignored_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !bus_start && !bus_stop && state == ST_CODE && dec.kind == FN_NONE)
      |=> (!gpio_req && !spi_go && $stable(cfg_reg) && $stable(idle_mode)));
endmodule

// File: tb/test_byte_cmd_bridge.sv
`timescale 1ns/1ps
module test_byte_cmd_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr_strap = 3'b101;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, tx_valid, addr_hit, spi_go, irq, idle_mode, gpio_req;
  logic [7:0] tx_data, spi_len, spi_rd_data, cfg_reg, gpio_data, ovf_cnt;
  logic [3:0] spi_cs;
  logic [1:0] gpio_op;
  logic [7:0] spi_rd_idx = 0, spi_wr_idx = 0, spi_wr_data = 0;
  logic spi_wr_en = 0, spi_done = 0;

  int checks = 0, errors = 0, popped = 0, gpio_pulses = 0;
  logic [7:0] exp_q[$];
  logic [7:0] sent[$];
  localparam logic [6:0] OWN = 7'h2D;

  always #2.5 clk = ~clk;

  byte_cmd_bridge i_byte_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .addr_hit(addr_hit), .spi_go(spi_go), .spi_len(spi_len), .spi_cs(spi_cs),
    .spi_rd_idx(spi_rd_idx), .spi_rd_data(spi_rd_data),
    .spi_wr_en(spi_wr_en), .spi_wr_idx(spi_wr_idx), .spi_wr_data(spi_wr_data),
    .spi_done(spi_done), .cfg_reg(cfg_reg), .irq(irq), .idle_mode(idle_mode),
    .gpio_req(gpio_req), .gpio_op(gpio_op), .gpio_data(gpio_data),
    .ovf_cnt(ovf_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: a handshake happens at the next rising edge
  always @(negedge clk) begin
    #1;
    if (tx_valid && tx_ready) begin
      popped++;
      if (exp_q.size() == 0) chk(0, "R10 unexpected read byte", tx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e, "R10 read data", tx_data, e);
      end
    end
    if (gpio_req) gpio_pulses++;
  end

  task automatic start_ev();
    @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
  endtask
  task automatic stop_ev();
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic send(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    while (1) begin
      ok = rx_ready;
      @(negedge clk);
      if (ok) break;
    end
    rx_valid = 0;
  endtask
  task automatic read_n(input int n);
    int target;
    start_ev();
    send({OWN, 1'b1});
    target = popped + n;
    tx_ready = 1;
    while (popped < target) @(negedge clk);
    tx_ready = 0;
    stop_ev();
  endtask
  // model engine: returns each byte XOR 0xA5
  task automatic serve_spi();
    int n;
    n = int'(spi_len);
    for (int i = 0; i < n; i++) begin
      spi_rd_idx = 8'(i);
      #1;
      spi_wr_data = spi_rd_data ^ 8'hA5;
      spi_wr_idx = 8'(i);
      spi_wr_en = 1;
      chk(!rx_ready && !tx_valid, "R4 stalled while busy", rx_ready, 0);
      @(negedge clk);
    end
    spi_wr_en = 0;
    spi_done = 1;
    @(negedge clk);
    spi_done = 0;
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!addr_hit && !spi_go && !irq && !idle_mode && !gpio_req && !tx_valid,
        "R11 reset flags", {addr_hit, spi_go, irq, idle_mode, gpio_req, tx_valid}, 0);
    chk(cfg_reg == 0 && ovf_cnt == 0 && rx_ready, "R11 reset regs", cfg_reg, 0);

    // R1 foreign address: bytes ignored
    start_ev(); send({7'h2C, 1'b0});
    chk(!addr_hit, "R1 foreign address", addr_hit, 0);
    send(8'hF0); send(8'h55); stop_ev();
    chk(cfg_reg == 0, "R1 foreign bytes ignored", cfg_reg, 0);

    // R6 configure, extra byte ignored
    start_ev(); send({OWN, 1'b0});
    chk(addr_hit, "R1 own address", addr_hit, 1);
    send(8'hF0); send(8'h6C);
    chk(cfg_reg == 8'h6C, "R6 config load", cfg_reg, 8'h6C);
    send(8'h11);
    chk(cfg_reg == 8'h6C, "R6 extra byte ignored", cfg_reg, 8'h6C);
    stop_ev();
    chk(!addr_hit, "R1 hit clears at stop", addr_hit, 0);

    // R7 idle mode
    start_ev(); send({OWN, 1'b0}); send(8'hF2); stop_ev();
    chk(idle_mode, "R7 idle set", idle_mode, 1);
    start_ev(); send({OWN, 1'b0});
    chk(!idle_mode, "R7 idle cleared by match", idle_mode, 0);
    stop_ev();

    // R9 ignored codes
    foreach (sent[i]) sent.delete();
    for (int k = 0; k < 3; k++) begin
      logic [7:0] c;
      c = (k == 0) ? 8'h00 : (k == 1) ? 8'hF3 : 8'hFA;
      start_ev(); send({OWN, 1'b0}); send(c); send(8'h42); send(8'h07); stop_ev();
      @(negedge clk);
      chk(cfg_reg == 8'h6C && !irq && !idle_mode && !spi_go && gpio_pulses == 0,
          "R9 ignored code", c, 0);
    end

    // R8 GPIO operations
    start_ev(); send({OWN, 1'b0}); send(8'hF4); send(8'h03);
    chk(gpio_req && gpio_op == 0 && gpio_data == 8'h03, "R8 gpio write",
        {gpio_req, gpio_op, gpio_data}, {1'b1, 2'd0, 8'h03});
    stop_ev();
    start_ev(); send({OWN, 1'b0}); send(8'hF5);
    chk(gpio_req && gpio_op == 1 && gpio_data == 0, "R8 gpio read",
        {gpio_req, gpio_op, gpio_data}, {1'b1, 2'd1, 8'h00});
    stop_ev();
    start_ev(); send({OWN, 1'b0}); send(8'hF6); send(8'h01);
    chk(gpio_req && gpio_op == 2 && gpio_data == 8'h01, "R8 gpio enable",
        {gpio_req, gpio_op, gpio_data}, {1'b1, 2'd2, 8'h01});
    stop_ev();
    start_ev(); send({OWN, 1'b0}); send(8'hF7); send(8'h02);
    chk(gpio_req && gpio_op == 3 && gpio_data == 8'h02, "R8 gpio configure",
        {gpio_req, gpio_op, gpio_data}, {1'b1, 2'd3, 8'h02});
    stop_ev();
    chk(gpio_pulses == 4, "R8 one pulse per op", gpio_pulses, 4);

    // R10 read before any transfer
    exp_q.push_back(8'hFF);
    read_n(1);

    // R2 zero-byte transfer launches nothing
    start_ev(); send({OWN, 1'b0}); send(8'h03);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    chk(!spi_go && rx_ready, "R2 no launch without data", spi_go, 0);

    // R2 transfer of 4 bytes on select bitmap 5
    sent = '{8'h12, 8'h34, 8'h56, 8'h78};
    start_ev(); send({OWN, 1'b0}); send(8'h05);
    foreach (sent[i]) send(sent[i]);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    chk(spi_go && spi_len == 4 && spi_cs == 4'h5, "R2 launch",
        {spi_go, spi_len, spi_cs}, {1'b1, 8'd4, 4'h5});
    chk(!rx_ready && !tx_valid, "R4 stall at launch", rx_ready, 0);
    @(negedge clk);
    chk(!spi_go, "R2 single pulse", spi_go, 0);
    serve_spi();
    chk(irq && rx_ready, "R5 irq set on done", irq, 1);
    foreach (sent[i]) exp_q.push_back(sent[i] ^ 8'hA5);
    exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
    read_n(6);

    // R5 irq holds through other commands, cleared by 0xF1
    start_ev(); send({OWN, 1'b0}); send(8'hF0); send(8'h21); stop_ev();
    chk(irq, "R5 irq held", irq, 1);
    start_ev(); send({OWN, 1'b0}); send(8'hF1);
    chk(!irq, "R5 irq cleared", irq, 0);
    stop_ev();

    // R3 overflow: 203 bytes, 200 stored
    sent.delete();
    start_ev(); send({OWN, 1'b0}); send(8'h0F);
    for (int i = 0; i < 203; i++) begin
      sent.push_back(8'(i * 7 + 3));
      send(8'(i * 7 + 3));
    end
    chk(ovf_cnt == 3, "R3 overflow count", ovf_cnt, 3);
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    chk(spi_go && spi_len == 200 && spi_cs == 4'hF, "R3 capped length", spi_len, 200);
    serve_spi();
    for (int i = 0; i < 200; i++) exp_q.push_back(sent[i] ^ 8'hA5);
    exp_q.push_back(8'hFF);
    read_n(201);
    chk(exp_q.size() == 0, "R10 all reads delivered", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule